// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block is the distributor of a small interrupt controller. For every interrupt source it keeps an enable bit, a pending state, a group bit, a two-bit trigger configuration and an eight-bit priority. It takes the raw hardware interrupt lines and presents to a single CPU interface the best candidate among the interrupts that are enabled, pending and not already being serviced. Software reaches the state through a 32-bit, word-addressed read/write port. Enable and pending are changed through paired banks: one bank sets bits where 1s are written and the other clears them.

The CPU interface takes the presented interrupt with a one-cycle acknowledge pulse. That marks the interrupt active and drops any latched pending state. Completion is signalled with an end-of-interrupt pulse carrying the ID. Level-configured sources stay pending while their line is high. Edge-configured sources latch on a rising edge. The number of interrupts is a parameter and must be a multiple of 32. The default is 64.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the control word (address 0x000) reads 0, every enable and pending word reads 0, and fwd_valid is 0. Bits [4:0] of the type word (address 0x001) always read NUM_IRQ/32-1, which is 1 for 64 interrupts.
- R2: A write to set-enable word w (address 0x040+w) sets the enable bits that are written as 1 and leaves those written as 0 unchanged. Reads of set-enable word w and of clear-enable word w (address 0x060+w) both return the current enable bits.
- R3: A write to clear-enable word w clears the enable bits that are written as 1 and leaves all other enable bits unchanged.
- R4: In every one-bit-per-interrupt bank, interrupt N sits in word N>>5 at bit N&31. Its priority is byte N&3 (bits 8*(N&3)+7 down to 8*(N&3)) of priority word 0x100+(N>>2). Its configuration field is bits 2*(N&15)+1 and 2*(N&15) of configuration word 0x200+(N>>4). The upper bit of that field selects edge (1) or level (0).
- R5: Bit 0 of the control word gates forwarding. While it is 0, fwd_valid is 0.
- R6: A level interrupt is pending, one cycle after its line is sampled high, for as long as the line stays high. A clear-pending write does not drop it while the line is high.
- R7: An edge interrupt latches pending on a rising edge of its line, stays pending after the line falls, and is cleared by an acknowledge or by a clear-pending write.
- R8: Writing 1s to set-pending word w (address 0x080+w) latches those interrupts pending. Writing 1s to clear-pending word w (address 0x0A0+w) drops those latches. Both words read back the pending state.
- R9: fwd_id and fwd_prio give the interrupt with the lowest priority value among those that are enabled, pending and not active. Ties go to the lowest ID.
- R10: cpu_ack while fwd_valid is 1 makes fwd_id active and clears its latched pending state. An active interrupt is not forwarded until cpu_eoi arrives with its ID.
- R11: A rising edge that is seen in the same cycle as an acknowledge of that edge interrupt keeps it pending. A rising edge in the same cycle as a clear-pending write of that interrupt also keeps it pending.
- R12: Addresses outside the map, and words beyond NUM_IRQ in a bank, read 0 and ignore writes. The type word ignores writes.
- R13: Group word w (address 0x0C0+w) stores and reads back one bit per interrupt and does not change forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Hardware interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_ack | input | 1 | Acknowledge of the forwarded interrupt |
| cpu_eoi | input | 1 | End of interrupt |
| eoi_id | input | ID_W | ID that cpu_eoi completes |
| fwd_valid | output | 1 | An interrupt is being forwarded |
| fwd_id | output | ID_W | ID of the forwarded interrupt |
| fwd_prio | output | 8 | Priority of the forwarded interrupt |

## Verification
The collision that matters is a fresh rising edge on an edge-configured line that lands in the same cycle as the acknowledge which would clear that interrupt's latch. The bench holds an edge interrupt pending and forwarded, raises its line one cycle before it pulses cpu_ack, so that the registered edge detector fires while the acknowledge is taken. It then expects the interrupt to read back pending yet to stay off the output while active, and to come back after its end-of-interrupt. Randomised priorities (restricted to a few values so that ties are frequent), enable masks and level lines check the arbitration against a bench model that takes the minimum priority first and then the lowest ID.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 8;

  // word address map, one bank per base; bank index added to base
  localparam logic [ADDR_W-1:0] A_CTRL   = 10'h000;
  localparam logic [ADDR_W-1:0] A_TYPE   = 10'h001;
  localparam logic [ADDR_W-1:0] A_SETEN  = 10'h040;
  localparam logic [ADDR_W-1:0] A_CLREN  = 10'h060;
  localparam logic [ADDR_W-1:0] A_SETPND = 10'h080;
  localparam logic [ADDR_W-1:0] A_CLRPND = 10'h0A0;
  localparam logic [ADDR_W-1:0] A_GROUP  = 10'h0C0;
  localparam logic [ADDR_W-1:0] A_PRIO   = 10'h100;
  localparam logic [ADDR_W-1:0] A_CFG    = 10'h200;

  function automatic logic [ADDR_W-1:0] bank_addr(logic [ADDR_W-1:0] base, int idx);
    return base + ADDR_W'(idx);
  endfunction

  // candidate displaces the current best only on a strictly lower value
  function automatic logic outranks(logic [PRIO_W-1:0] cand_p, logic [PRIO_W-1:0] best_p,
                                    logic have_best);
    return !have_best || (cand_p < best_p);
  endfunction
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  input  logic [NUM_IRQ-1:0]        pend_eff,
  output logic                      ctrl_en,
  output logic [NUM_IRQ-1:0]        enable_q,
  output logic [PRIO_W*NUM_IRQ-1:0] prio_q,
  output logic [NUM_IRQ-1:0]        edge_cfg,
  output logic [NUM_IRQ-1:0]        set_pnd,
  output logic [NUM_IRQ-1:0]        clr_pnd
);
  localparam int NW  = NUM_IRQ / 32;
  localparam int NPW = NUM_IRQ / 4;
  localparam int NCW = NUM_IRQ / 16;

  logic [NUM_IRQ-1:0]   group_q;
  logic [2*NUM_IRQ-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      enable_q <= '0;
      group_q  <= '0;
      prio_q   <= '0;
      cfg_q    <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_en <= wdata[0];
      for (int w = 0; w < NW; w++) begin
        if (addr == bank_addr(A_SETEN, w)) enable_q[w*32 +: 32] <= enable_q[w*32 +: 32] | wdata;
        if (addr == bank_addr(A_CLREN, w)) enable_q[w*32 +: 32] <= enable_q[w*32 +: 32] & ~wdata;
        if (addr == bank_addr(A_GROUP, w)) group_q[w*32 +: 32] <= wdata;
      end
      for (int k = 0; k < NPW; k++)
        if (addr == bank_addr(A_PRIO, k)) prio_q[k*32 +: 32] <= wdata;
      for (int k = 0; k < NCW; k++)
        if (addr == bank_addr(A_CFG, k)) cfg_q[k*32 +: 32] <= wdata;
    end
  end

  // upper bit of each two-bit field selects edge behaviour
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
    assign edge_cfg[i] = cfg_q[2*i+1];
  end

  always_comb begin
    set_pnd = '0;
    clr_pnd = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_en && addr == bank_addr(A_SETPND, w)) set_pnd[w*32 +: 32] = wdata;
      if (wr_en && addr == bank_addr(A_CLRPND, w)) clr_pnd[w*32 +: 32] = wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[0] = ctrl_en;
    if (addr == A_TYPE) rdata[4:0] = 5'(NW - 1);
    for (int w = 0; w < NW; w++) begin
      if (addr == bank_addr(A_SETEN, w) || addr == bank_addr(A_CLREN, w))
        rdata = enable_q[w*32 +: 32];
      if (addr == bank_addr(A_SETPND, w) || addr == bank_addr(A_CLRPND, w))
        rdata = pend_eff[w*32 +: 32];
      if (addr == bank_addr(A_GROUP, w)) rdata = group_q[w*32 +: 32];
    end
    for (int k = 0; k < NPW; k++)
      if (addr == bank_addr(A_PRIO, k)) rdata = prio_q[k*32 +: 32];
    for (int k = 0; k < NCW; k++)
      if (addr == bank_addr(A_CFG, k)) rdata = cfg_q[k*32 +: 32];
  end
endmodule

// File: rtl/irqd_pend.sv
module irqd_pend
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] edge_cfg,
  input  logic [NUM_IRQ-1:0] set_pnd,
  input  logic [NUM_IRQ-1:0] clr_pnd,
  input  logic               ack_take,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               eoi,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [NUM_IRQ-1:0] pend_eff,
  output logic [NUM_IRQ-1:0] active_q,
  output logic [NUM_IRQ-1:0] edge_rise
);
  logic [NUM_IRQ-1:0] irq_q, irq_p, latch_q, ack_hit, eoi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irq_p <= '0;
    end else begin
      irq_q <= irq_in;
      irq_p <= irq_q;
    end
  end

  assign edge_rise = irq_q & ~irq_p;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign ack_hit[i]  = ack_take && (ack_id == ID_W'(i));
    assign eoi_hit[i]  = eoi && (eoi_id == ID_W'(i));
    assign pend_eff[i] = latch_q[i] | (~edge_cfg[i] & irq_q[i]);
  end

  // a new edge or a software set beats any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      active_q <= '0;
    end else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if ((edge_cfg[i] && edge_rise[i]) || set_pnd[i]) latch_q[i] <= 1'b1;
        else if (clr_pnd[i] || ack_hit[i])               latch_q[i] <= 1'b0;
        if (ack_hit[i])      active_q[i] <= 1'b1;
        else if (eoi_hit[i]) active_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [PRIO_W*NUM_IRQ-1:0] prio_q,
  input  logic                      gate,
  output logic                      fwd_valid,
  output logic [ID_W-1:0]           fwd_id,
  output logic [PRIO_W-1:0]         fwd_prio
);
  logic              have;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_p;

  // ascending scan: equal values never displace an earlier ID
  always_comb begin
    have    = 1'b0;
    best_id = '0;
    best_p  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && outranks(prio_q[i*PRIO_W +: PRIO_W], best_p, have)) begin
        have    = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_q[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign fwd_valid = gate & have;
  assign fwd_id    = best_id;
  assign fwd_prio  = best_p;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter  int NUM_IRQ = 64,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               cpu_ack,
  input  logic               cpu_eoi,
  input  logic [ID_W-1:0]    eoi_id,
  output logic               fwd_valid,
  output logic [ID_W-1:0]    fwd_id,
  output logic [PRIO_W-1:0]  fwd_prio
);
  logic                      ctrl_en;
  logic [NUM_IRQ-1:0]        enable_q, edge_cfg, set_pnd, clr_pnd;
  logic [NUM_IRQ-1:0]        pend_eff, active_q, edge_rise, cand;
  logic [PRIO_W*NUM_IRQ-1:0] prio_q;
  logic                      ack_take;

  irqd_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .pend_eff(pend_eff), .ctrl_en(ctrl_en), .enable_q(enable_q),
    .prio_q(prio_q), .edge_cfg(edge_cfg), .set_pnd(set_pnd), .clr_pnd(clr_pnd)
  );

  assign ack_take = cpu_ack & fwd_valid;

  irqd_pend #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_cfg(edge_cfg), .set_pnd(set_pnd),
    .clr_pnd(clr_pnd), .ack_take(ack_take), .ack_id(fwd_id), .eoi(cpu_eoi),
    .eoi_id(eoi_id), .pend_eff(pend_eff), .active_q(active_q), .edge_rise(edge_rise)
  );

  assign cand = enable_q & pend_eff & ~active_q;

  irqd_arb #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_arb (
    .cand(cand), .prio_q(prio_q), .gate(ctrl_en),
    .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
  );
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ID_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               cpu_ack,
  input logic               cpu_eoi,
  input logic [ID_W-1:0]    eoi_id,
  input logic               fwd_valid,
  input logic [ID_W-1:0]    fwd_id,
  input logic [NUM_IRQ-1:0] enable_q,
  input logic [NUM_IRQ-1:0] pend_eff,
  input logic [NUM_IRQ-1:0] active_q,
  input logic [NUM_IRQ-1:0] edge_rise,
  input logic [NUM_IRQ-1:0] edge_cfg
);
  AST_TYPE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_TYPE) |-> (bus_rdata[4:0] == 5'(NUM_IRQ/32 - 1))); // R1

  AST_SETEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SETEN) |=>
      ((enable_q[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_CLREN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLREN) |=> ((enable_q[31:0] & $past(bus_wdata)) == '0)); // R3

  AST_FWD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (enable_q[fwd_id] && pend_eff[fwd_id] && !active_q[fwd_id])); // R9

  AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && fwd_valid) |=> active_q[$past(fwd_id)]); // R10

  AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi && !(cpu_ack && fwd_valid && fwd_id == eoi_id)) |=> !active_q[$past(eoi_id)]); // R10

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_rise & edge_cfg)) |=>
      ((pend_eff & $past(edge_rise & edge_cfg)) == $past(edge_rise & edge_cfg))); // R11
endmodule

bind irq_distributor irqd_chk #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .eoi_id(eoi_id),
  .fwd_valid(fwd_valid), .fwd_id(fwd_id), .enable_q(enable_q), .pend_eff(pend_eff),
  .active_q(active_q), .edge_rise(edge_rise), .edge_cfg(edge_cfg)
);

// File: tb/irq_distributor_tb.sv
`timescale 1ns/1ps
module irq_distributor_tb;
  import irqd_pkg::*;
  localparam int N   = 64;
  localparam int IDW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [N-1:0]      irq_in = '0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              cpu_ack = 1'b0, cpu_eoi = 1'b0;
  logic [IDW-1:0]    eoi_id = '0;
  logic              fwd_valid;
  logic [IDW-1:0]    fwd_id;
  logic [7:0]        fwd_prio;

  irq_distributor #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
    .eoi_id(eoi_id), .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_prio [N];
  logic [N-1:0] m_en;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(logic v, logic [IDW-1:0] id, logic [7:0] p);
    return {17'b0, v, id, p};
  endfunction

  // minimum value first, then the first ID holding it
  function automatic logic [31:0] model_win(logic [N-1:0] c);
    int mn = 256;
    for (int i = 0; i < N; i++) if (c[i] && int'(m_prio[i]) < mn) mn = int'(m_prio[i]);
    if (mn == 256) return pack(1'b0, '0, '0);
    for (int i = 0; i < N; i++)
      if (c[i] && int'(m_prio[i]) == mn) return pack(1'b1, IDW'(i), 8'(mn));
    return '0;
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(string req, logic [31:0] exp);
    @(negedge clk); #1; chk(req, pack(fwd_valid, fwd_id, fwd_prio), exp);
  endtask

  task automatic do_ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic do_eoi(int id);
    @(negedge clk); cpu_eoi = 1'b1; eoi_id = IDW'(id);
    @(negedge clk); cpu_eoi = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, e, exp;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    m_en = '0;
    idle(3); rst_n = 1'b1; idle(1);

    rd(A_CTRL, d);   chk("R1 ctrl reset", d, 32'h0);
    rd(A_TYPE, d);   chk("R1 type word", d, 32'h1);
    rd(A_SETEN, d);  chk("R1 enable reset", d, 32'h0);
    rd(A_SETPND, d); chk("R1 pending reset", d, 32'h0);
    #1; chk("R1 fwd reset", {31'b0, fwd_valid}, 32'h0);

    // random arbitration over level lines, with acknowledge and completion
    wr(A_CTRL, 32'h1);
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < N/4; k++) begin
        d = $urandom & 32'h0303_0303;
        wr(bank_addr(A_PRIO, k), d);
        for (int j = 0; j < 4; j++) m_prio[4*k+j] = d[8*j +: 8];
      end
      for (int w = 0; w < N/32; w++) begin
        wr(bank_addr(A_CLREN, w), 32'hFFFF_FFFF);
        e = $urandom;
        wr(bank_addr(A_SETEN, w), e);
        m_en[w*32 +: 32] = e;
      end
      irq_in = {$urandom, $urandom};
      idle(2);
      exp = model_win(m_en & irq_in);
      look("R9 random arbitration", exp);
      if (exp[14]) begin
        do_ack();
        #1;
        chk("R10 random after ack", pack(fwd_valid, fwd_id, fwd_prio),
            model_win(m_en & irq_in & ~(64'd1 << exp[13:8])));
        do_eoi(int'(exp[13:8]));
      end
      irq_in = '0;
      idle(2);
    end

    // directed: clean slate
    for (int w = 0; w < N/32; w++) wr(bank_addr(A_CLREN, w), 32'hFFFF_FFFF);
    for (int k = 0; k < N/4; k++) wr(bank_addr(A_PRIO, k), 32'h0);

    wr(A_SETEN, 32'h0000_00F0); rd(A_SETEN, d); chk("R2 set ones", d, 32'hF0);
    wr(A_SETEN, 32'h0000_000F); rd(A_SETEN, d); chk("R2 zeros no effect", d, 32'hFF);
    rd(A_CLREN, d); chk("R2 clear bank reads enables", d, 32'hFF);
    wr(A_CLREN, 32'h0000_0030); rd(A_SETEN, d); chk("R3 clear ones", d, 32'hCF);
    wr(A_CLREN, 32'hFFFF_FFFF); rd(A_CLREN, d); chk("R3 clear all", d, 32'h0);

    rd(10'h3FF, d); chk("R12 unmapped read", d, 32'h0);
    wr(10'h3FF, 32'hFFFF_FFFF); rd(10'h3FF, d); chk("R12 unmapped write", d, 32'h0);
    wr(A_TYPE, 32'hFF); rd(A_TYPE, d); chk("R12 type read-only", d, 32'h1);
    wr(bank_addr(A_SETEN, 2), 32'hFFFF_FFFF);
    rd(bank_addr(A_SETEN, 2), d); chk("R12 word beyond range", d, 32'h0);
    rd(bank_addr(A_SETEN, 1), d); chk("R12 no alias into word 1", d, 32'h0);

    // ID 45: word 1 bit 13, priority word 11 byte 1
    wr(bank_addr(A_SETEN, 1), 32'h0000_2000);
    wr(bank_addr(A_SETPND, 1), 32'h0000_2000);
    wr(bank_addr(A_PRIO, 11), 32'h0000_2000);
    look("R4 id 45 forwarded", pack(1'b1, 6'd45, 8'h20));
    rd(bank_addr(A_SETPND, 1), d); chk("R8 set-pending readback", d, 32'h2000);
    wr(A_CTRL, 32'h0); look("R5 gate off", pack(1'b0, 6'd45, 8'h20));
    wr(A_CTRL, 32'h1); look("R5 gate on", pack(1'b1, 6'd45, 8'h20));
    wr(bank_addr(A_CLRPND, 1), 32'h0000_2000);
    rd(bank_addr(A_CLRPND, 1), d); chk("R8 clear-pending", d, 32'h0);
    wr(bank_addr(A_CLREN, 1), 32'hFFFF_FFFF);

    // level ID 3
    wr(A_SETEN, 32'h0000_0008);
    irq_in[3] = 1'b1; idle(2);
    look("R6 level forwarded", pack(1'b1, 6'd3, 8'h0));
    wr(A_CLRPND, 32'h0000_0008);
    rd(A_SETPND, d); chk("R6 clear ignored while high", d, 32'h8);
    irq_in[3] = 1'b0; idle(2);
    rd(A_SETPND, d); chk("R6 drops with line", d, 32'h0);

    // edge ID 5: config word 0 bit 11
    wr(A_CFG, 32'h0000_0800);
    wr(A_SETEN, 32'h0000_0020);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); irq_in[5] = 1'b0;
    idle(3);
    rd(A_SETPND, d); chk("R7 edge latched after fall", d, 32'h20);
    look("R7 edge forwarded", pack(1'b1, 6'd5, 8'h0));
    do_ack();
    rd(A_SETPND, d); chk("R7 ack clears edge", d, 32'h0);
    do_eoi(5);

    // collision: rising edge seen in the cycle the acknowledge is taken
    wr(A_SETPND, 32'h0000_0020);
    look("R11 setup", pack(1'b1, 6'd5, 8'h0));
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0; irq_in[5] = 1'b0;
    rd(A_SETPND, d); chk("R11 edge beats ack", d, 32'h20);
    #1; chk("R11 held while active", {31'b0, fwd_valid}, 32'h0);
    do_eoi(5);
    look("R11 returns after eoi", pack(1'b1, 6'd5, 8'h0));
    do_ack(); do_eoi(5);

    // ties and active exclusion with IDs 7 and 10
    wr(A_CFG, 32'h0);
    wr(A_CLREN, 32'hFFFF_FFFF);
    wr(A_SETEN, 32'h0000_0480);
    wr(bank_addr(A_PRIO, 1), 32'h0500_0000);
    wr(bank_addr(A_PRIO, 2), 32'h0005_0000);
    wr(A_SETPND, 32'h0000_0480);
    look("R9 tie lowest id", pack(1'b1, 6'd7, 8'h05));
    wr(bank_addr(A_PRIO, 2), 32'h0003_0000);
    look("R9 lower value wins", pack(1'b1, 6'd10, 8'h03));
    do_ack(); #1;
    chk("R10 active excluded", pack(fwd_valid, fwd_id, fwd_prio), pack(1'b1, 6'd7, 8'h05));
    rd(A_SETPND, d); chk("R10 ack clears latch", d, 32'h80);
    wr(A_SETPND, 32'h0000_0400);
    look("R10 repend while active", pack(1'b1, 6'd7, 8'h05));
    do_eoi(10);
    look("R10 back after eoi", pack(1'b1, 6'd10, 8'h03));

    wr(bank_addr(A_GROUP, 1), 32'h0000_A5A5);
    rd(bank_addr(A_GROUP, 1), d); chk("R13 group readback", d, 32'hA5A5);
    look("R13 group no effect", pack(1'b1, 6'd10, 8'h03));

    finish_run();
  end
endmodule